// File: doc/BRIEF.md
# Master Clock Ratio Prescaler

This block works out the speed of the master clock on its own. It counts master-clock cycles between rising edges of the 8 kHz transmit frame sync. It matches the count against a fixed set of supported ratios and reports the matching rate as a code. No pin or register chooses the rate. Once two frames in a row give the same supported count, the block raises its lock flag. From then on it produces a one-cycle sequencing enable at 256 kHz, which is 32 pulses per frame. This enable restarts on every frame-sync rising edge.

Frame sync must be synchronous to the master clock, and the block samples it on the rising master-clock edge. One supported ratio, 193 cycles per frame, is not a multiple of 32. In that case the extra cycle is absorbed by lengthening the last enable interval, so every frame still carries exactly 32 pulses. The block drops lock in two cases:

- a count that is not on the list arrives;
- frame sync stops arriving.

Top module: `mclk_ratio_prescaler`

## Requirements
- R1: During and right after reset, `locked`, `rate_code`, `en256` and `rate_invalid` are all 0.
- R2: A frame period is the number of master-clock cycles from one frame-sync rising edge to the next. It is classified with this code mapping:

  | Period (cycles) | Code |
  |---|---|
  | 32 | 0 |
  | 64 | 1 |
  | 192 | 2 |
  | 193 | 3 |
  | 256 | 4 |
  | 320 | 5 |
  | 512 | 6 |

  `rate_code` shows the code of the period that produced the most recent lock.
- R3: After a fresh start, `locked` rises at the third frame-sync rising edge when the two periods before it are equal and on the list. The flag is registered: it is seen one cycle after the edge.
- R4: A listed period that differs from the period before it clears `locked` at the rising edge that ends it. Two further equal periods lock again.
- R5: A period that is not on the list clears `locked` and sets `rate_invalid`. The next listed period clears `rate_invalid`.
- R6: While locked, `en256` pulses for one cycle at offsets k*S, for k = 0..31. Offset 0 is the cycle right after the frame-sync rising edge. S is the locked period divided by 32, so S is 1, 2, 6, 8, 10 or 16.
- R7: At code 3 (period 193), pulses sit every 6 cycles and the 32nd interval lasts 7 cycles.
- R8: `en256` stays 0 while unlocked. It gives no more than 32 pulses between two frame-sync rising edges.
- R9: Suppose no frame-sync rising edge arrives for 601 cycles after the last one. Then `locked` falls, seen at offset 601. The next rising edge only starts a new measurement, so a fresh lock again takes three edges.
- R10: While `locked` stays high, `rate_code` does not change. After lock is lost, it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | 8 kHz frame sync, synchronous to mclk |
| rate_code | output | 3 | Detected rate code (see R2) |
| locked | output | 1 | Rate confirmed by two equal periods |
| en256 | output | 1 | One-cycle 256 kHz sequencing enable |
| rate_invalid | output | 1 | Last measured period was not a supported ratio |

## Verification
The hardest case to reach is the loss of frame sync. Only a frame longer than 601 cycles can cause it. Afterwards the first rising edge must not be taken as a measurement, so a fresh lock needs three edges. The stimulus drives a 700-cycle frame straight after a lock and then supplies steady frames. The stretched 193-cycle interval and rate changes in mid-lock also get directed frames. A seeded random mix of listed and unlisted periods, with run lengths of one to four frames, reaches the remaining lock and relock orderings.

// File: rtl/mclk_ratio_prescaler.sv
module mclk_ratio_prescaler #(
  parameter int CNT_W   = 10,
  parameter int TIMEOUT = 600,
  parameter int PULSES  = 32
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       fsync,
  output logic [2:0] rate_code,
  output logic       locked,
  output logic       en256,
  output logic       rate_invalid
);
  localparam int IDX_W = $clog2(PULSES + 1);
  localparam int PH_W  = 6;
  localparam logic [CNT_W-1:0] TMO  = CNT_W'(TIMEOUT);
  localparam logic [IDX_W-1:0] NPUL = IDX_W'(PULSES);

  logic             fs_q, have_ref, prev_ok, meas_ok;
  logic [2:0]       prev_code, meas_code;
  logic [CNT_W-1:0] cnt;
  logic [PH_W-1:0]  ph, lim;
  logic [IDX_W-1:0] pidx;

  wire rise = fsync & ~fs_q;

  function automatic int nominal(input logic [2:0] c);
    case (c)
      3'd0: return 32;
      3'd1: return 64;
      3'd2: return 192;
      3'd3: return 193;
      3'd4: return 256;
      3'd5: return 320;
      default: return 512;
    endcase
  endfunction

  always_comb begin
    meas_ok   = 1'b1;
    meas_code = 3'd0;
    case (int'(cnt) + 1)
      32:  meas_code = 3'd0;
      64:  meas_code = 3'd1;
      192: meas_code = 3'd2;
      193: meas_code = 3'd3;
      256: meas_code = 3'd4;
      320: meas_code = 3'd5;
      512: meas_code = 3'd6;
      default: meas_ok = 1'b0;
    endcase
  end

  always_comb begin
    int n;
    n   = nominal(rate_code);
    lim = PH_W'(n / PULSES - 1 + ((pidx == NPUL - IDX_W'(1)) ? n % PULSES : 0));
  end

  assign en256 = locked && (pidx < NPUL) && (ph == '0);

  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      fs_q         <= 1'b0;
      cnt          <= '0;
      have_ref     <= 1'b0;
      prev_ok      <= 1'b0;
      prev_code    <= 3'd0;
      locked       <= 1'b0;
      rate_code    <= 3'd0;
      rate_invalid <= 1'b0;
      ph           <= '0;
      pidx         <= NPUL;
    end else begin
      fs_q <= fsync;
      if (rise) begin
        cnt      <= '0;
        ph       <= '0;
        pidx     <= '0;
        have_ref <= 1'b1;
        if (have_ref) begin
          prev_code    <= meas_code;
          prev_ok      <= meas_ok;
          rate_invalid <= !meas_ok;
          if (meas_ok && prev_ok && prev_code == meas_code) begin
            locked    <= 1'b1;
            rate_code <= meas_code;
          end else begin
            locked <= 1'b0;
          end
        end
      end else begin
        if (cnt != TMO) cnt <= cnt + CNT_W'(1);
        else begin
          locked   <= 1'b0;
          have_ref <= 1'b0;
          prev_ok  <= 1'b0;
        end
        if (pidx < NPUL) begin
          if (ph == lim) begin
            ph   <= '0;
            pidx <= pidx + IDX_W'(1);
          end else begin
            ph <= ph + PH_W'(1);
          end
        end
      end
    end
  end

  assert_lock_not_invalid_R5: assert property (@(posedge mclk) disable iff (!rst_n)
    locked |-> !rate_invalid);
  assert_lock_on_edge_R3: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(locked) |-> ($past(fsync) && !$past(fs_q)));
  assert_first_pulse_R6: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(locked) |-> en256);
  assert_count_bound_R9: assert property (@(posedge mclk) disable iff (!rst_n)
    cnt <= TMO);
  assert_pulse_limit_R8: assert property (@(posedge mclk) disable iff (!rst_n)
    pidx <= NPUL);
  assert_code_hold_R10: assert property (@(posedge mclk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(rate_code));
endmodule

// File: tb/test_mclk_ratio_prescaler.sv
`timescale 1ns/1ps
module test_mclk_ratio_prescaler;
  logic mclk = 0, rst_n = 0, fsync = 0;
  logic [2:0] rate_code;
  logic locked, en256, rate_invalid;
  int checks = 0, errors = 0;
  int last_len = 0, prevc = -1, erate = 0;
  bit el = 0, einv = 0;

  always #5 mclk = ~mclk;

  mclk_ratio_prescaler i_mclk_ratio_prescaler (
    .mclk(mclk), .rst_n(rst_n), .fsync(fsync), .rate_code(rate_code),
    .locked(locked), .en256(en256), .rate_invalid(rate_invalid));

  function automatic int classify(int n);
    case (n)
      32: return 0; 64: return 1; 192: return 2; 193: return 3;
      256: return 4; 320: return 5; 512: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic int step_of(int c);
    case (c)
      0: return 1; 1: return 2; 2: return 6; 3: return 6;
      4: return 8; 5: return 10; default: return 16;
    endcase
  endfunction

  function automatic bit exp_pulse(bit lk, int c, int o);
    int s = step_of(c);
    return lk && (o % s == 0) && (o / s < 32);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_frame(int n);
    bit tout = 0;
    int c;
    fsync = 1;
    @(posedge mclk);
    if (last_len != 0) begin
      c = classify(last_len);
      if (c < 0) begin el = 0; einv = 1; prevc = -1; end
      else begin
        einv = 0;
        if (c == prevc) begin el = 1; erate = c; end
        else el = 0;
        prevc = c;
      end
    end
    @(negedge mclk);
    fsync = 0;
    for (int o = 0; o < n; o++) begin
      if (o > 0) begin @(posedge mclk); @(negedge mclk); end
      if (o == 601) begin el = 0; tout = 1; prevc = -1; end
      chk(o >= 601 ? "R9" : "R3 R4", locked, el);
      chk("R2 R10", rate_code, erate);
      chk("R5", rate_invalid, einv);
      chk(!el ? "R8" : (erate == 3 ? "R7" : "R6"), en256, exp_pulse(el, erate, o));
    end
    last_len = tout ? 0 : n;
  endtask

  task automatic run_rate(int n, int frames);
    for (int f = 0; f < frames; f++) run_frame(n);
  endtask

  initial begin
    repeat (200000) @(posedge mclk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lst[7] = '{32, 64, 192, 193, 256, 320, 512};
    int n;
    void'($urandom(32'd4711));
    repeat (3) @(posedge mclk);
    @(negedge mclk);
    // R1 reset state
    chk("R1", locked, 0); chk("R1", rate_code, 0);
    chk("R1", en256, 0);  chk("R1", rate_invalid, 0);
    rst_n = 1;
    @(negedge mclk);
    chk("R1", locked, 0); chk("R1", en256, 0);
    // R2 R3 R6 each listed rate
    foreach (lst[i]) run_rate(lst[i], 4);
    // R7 stretched interval
    run_rate(193, 5);
    // R4 change of rate while locked, then relock
    run_rate(256, 4); run_rate(320, 4);
    // R5 unlisted period after lock, then recovery
    run_rate(100, 1); run_rate(64, 4);
    run_rate(600, 2); run_rate(512, 4);
    // R9 frame sync lost while locked
    run_frame(700); run_rate(512, 4);
    run_rate(32, 3); run_frame(650); run_rate(32, 3);
    for (int it = 0; it < 40; it++) begin
      if ($urandom % 5 == 0) begin
        n = 20 + int'($urandom % 500);
        if (classify(n) >= 0) n = n + 3;
      end else n = lst[$urandom % 7];
      run_rate(n, 1 + int'($urandom % 4));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule